// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends characters over one asynchronous serial line and makes its own bit clock. A host places a character into a single holding stage with a one-cycle write strobe. At the next bit boundary the character moves into a shift stage. It then leaves the block least significant bit first, framed by a low start bit and a high stop bit. Characters are 8 or 9 data bits long. In 9-bit mode the extra bit comes from a separate input that is captured with the write, not from the data bus.

The bit period is the clock period times (divisor + 1) times a multiplier. The multiplier is 64 in normal asynchronous mode, 16 in high-speed mode, and 4 when the synchronous-mode control is set. A transmit-enable control runs the block. Dropping it flushes everything. A separate port-enable control connects the shift stage to the line. Status outputs report an empty shift stage and a free holding stage, and an interrupt output reports the free holding stage when the interrupt is enabled.

Top module: `uart_tx_buf`

## Requirements
- R1: While `tx_en` is high, each serial bit lasts exactly (`divisor`+1)×M clock cycles, where M is the multiplier.
- R2: M is 64 when `sync_mode`=0 and `hi_speed`=0, 16 when `sync_mode`=0 and `hi_speed`=1, and 4 when `sync_mode`=1 (whatever the value of `hi_speed`).
- R3: A frame with `nine_bit`=0 is one low start bit, then `wr_data` bits 0 to 7 in that order, then one high stop bit. The line idles high.
- R4: A frame with `nine_bit`=1 places the `bit9_in` value captured at the write as a ninth data bit, after data bit 7 and before the stop bit.
- R5: If the holding stage is full when a stop bit ends, the next start bit begins on that same bit boundary. Consecutive start edges are then exactly (frame bits)×(bit period) cycles apart.
- R6: A write while the holding stage is full is ignored. Only the first character is sent, and `hold_empty` and `tx_irq` stay low until that character moves to the shift stage.
- R7: `tx_irq` is high exactly when `int_en`=1, `tx_en`=1 and `hold_empty`=1.
- R8: While `port_en`=0, `txd` stays high.
- R9: `tsr_empty` is low from the first start bit until the last stop bit of a burst ends, and high when no frame is in progress.
- R10: Dropping `tx_en` flushes both stages. One cycle later `txd`=1, `tsr_empty`=1 and `hold_empty`=1. Writes made while `tx_en`=0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Runs the transmitter; low flushes it |
| port_en | input | 1 | Connects the shift stage to `txd` |
| sync_mode | input | 1 | Selects the x4 multiplier |
| hi_speed | input | 1 | Selects x16 instead of x64 in asynchronous mode |
| nine_bit | input | 1 | 9-bit character mode |
| bit9_in | input | 1 | Ninth data bit, captured with the write |
| divisor | input | 8 | Bit rate divisor; divide ratio is value plus one |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Character to send |
| int_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial line |
| tsr_empty | output | 1 | Shift stage has no frame in progress |
| hold_empty | output | 1 | Holding stage can take a character |
| tx_irq | output | 1 | Interrupt: holding stage free and enabled |

## Verification
The bench builds the block with its default 8-bit data and divisor widths. The divisor takes only the values 0 to 3, so that even an 11-bit frame at the x64 multiplier stays within a few thousand cycles. This makes every combination of `sync_mode` and `hi_speed` affordable together with back-to-back bursts in both character lengths. Bit periods and frame spacing are measured as exact cycle counts on the line, so an off-by-one in either the divisor counter or the multiplier stage shows up.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers for the buffered serial transmitter.
// Assumes: data width fixed per build, multiplier values 4/16/64.
package uart_tx_pkg;

    localparam int MULT_W = 7;

    // One queued character with its optional ninth bit.
    typedef struct packed {
        logic       b9;
        logic [7:0] data;
    } tx_char_t;

    // Maps the mode controls to the bit clock multiplier.
    function automatic logic [MULT_W-1:0] mult_of(input logic sync_m, input logic fast);
        if (sync_m)    return MULT_W'(4);
        else if (fast) return MULT_W'(16);
        else           return MULT_W'(64);
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
// Bit clock generator: a reloadable divisor counter (ratio divisor+1)
// followed by a prescale counter of ratio M. Emits a one-cycle tick per
// bit period. Assumes M >= 2; held cleared while run is low.
module uart_tx_baud #(
    parameter int DIV_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            run,
    input  logic [DIV_W-1:0]                divisor,
    input  logic [uart_tx_pkg::MULT_W-1:0]  mult,
    output logic                            bit_tick
);
    import uart_tx_pkg::*;

    logic [DIV_W-1:0]  div_cnt_q;
    logic [MULT_W-1:0] pre_cnt_q;
    logic              pre_tick;
    logic              pre_wrap;

    assign pre_tick = run && (div_cnt_q == '0);
    assign pre_wrap = (pre_cnt_q == mult - MULT_W'(1));
    assign bit_tick = pre_tick && pre_wrap;

    // Divisor stage: counts down from divisor to zero, then reloads.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   div_cnt_q <= '0;
        else if (pre_tick)    div_cnt_q <= divisor;
        else                  div_cnt_q <= div_cnt_q - DIV_W'(1);
    end

    // Prescale stage: counts divisor wraps up to M-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   pre_cnt_q <= '0;
        else if (pre_tick)    pre_cnt_q <= pre_wrap ? '0 : pre_cnt_q + MULT_W'(1);
    end

    // Ticks are never adjacent, since M is at least 4.
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

endmodule

// File: rtl/uart_tx_hold.sv
// Holding stage: one character of buffering between the host and the
// shift stage. Takes a write only when empty and enabled, and frees
// itself when the shift stage consumes it. Assumes consume only when full.
module uart_tx_hold (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  wr_en,
    input  logic [7:0]            wr_data,
    input  logic                  bit9_in,
    input  logic                  consume,
    output logic                  full,
    output uart_tx_pkg::tx_char_t chr
);
    import uart_tx_pkg::*;

    // Occupancy flag: set by an accepted write, cleared by consume or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)        full <= 1'b0;
        else if (consume)          full <= 1'b0;
        else if (wr_en && !full)   full <= 1'b1;
    end

    // Character store: captured only when the stage accepts a write.
    always_ff @(posedge clk) begin
        if (!rst_n)                        chr <= '0;
        else if (run && wr_en && !full)    chr <= '{b9: bit9_in, data: wr_data};
    end

    assert_hold_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !consume && run) |=> (full && $stable(chr)));

endmodule

// File: rtl/uart_tx_shift.sv
// Shift stage: on each bit tick either advances the current frame or,
// once the last bit finishes, loads the held character with start and
// stop bits so frames run back to back. Sends LSB first; idles high.
module uart_tx_shift #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  bit_tick,
    input  logic                  nine_bit,
    input  logic                  hold_full,
    input  uart_tx_pkg::tx_char_t chr,
    output logic                  consume,
    output logic                  line,
    output logic                  empty
);
    import uart_tx_pkg::*;

    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               last_bit;
    logic [FRAME_W-1:0] new_frame;
    logic [CNT_W-1:0]   new_len;

    assign last_bit = (cnt_q <= CNT_W'(1));
    assign consume  = bit_tick && last_bit && hold_full;

    // Frame builder: stop, optional ninth bit, data, start (LSB out first).
    always_comb begin
        if (nine_bit) begin
            new_frame = {1'b1, chr.b9, chr.data, 1'b0};
            new_len   = CNT_W'(FRAME_W);
        end else begin
            new_frame = {2'b11, chr.data, 1'b0};
            new_len   = CNT_W'(FRAME_W - 1);
        end
    end

    // Shift register and remaining bit count, advanced on bit ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sr_q  <= '1;
            cnt_q <= '0;
        end else if (bit_tick) begin
            if (!last_bit) begin
                sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
                cnt_q <= cnt_q - CNT_W'(1);
            end else if (hold_full) begin
                sr_q  <= new_frame;
                cnt_q <= new_len;
            end else begin
                sr_q  <= '1;
                cnt_q <= '0;
            end
        end
    end

    assign line  = sr_q[0];
    assign empty = (cnt_q == '0);

    assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> line);
    assert_shift_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bit_tick) |=> $stable(sr_q));

endmodule

// File: rtl/uart_tx_buf.sv
// Top: buffered asynchronous transmitter. Connects the bit clock
// generator, holding stage and shift stage, gates the line with the
// port enable and qualifies the interrupt. Assumes synchronous inputs.
module uart_tx_buf #(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             port_en,
    input  logic             sync_mode,
    input  logic             hi_speed,
    input  logic             nine_bit,
    input  logic             bit9_in,
    input  logic [DIV_W-1:0] divisor,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             int_en,
    output logic             txd,
    output logic             tsr_empty,
    output logic             hold_empty,
    output logic             tx_irq
);
    import uart_tx_pkg::*;

    logic              bit_tick;
    logic              consume;
    logic              hold_full;
    logic              line;
    tx_char_t          chr;
    logic [MULT_W-1:0] mult;

    assign mult = mult_of(sync_mode, hi_speed);

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(tx_en), .divisor(divisor),
        .mult(mult), .bit_tick(bit_tick)
    );

    uart_tx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .run(tx_en), .wr_en(wr_en),
        .wr_data(wr_data), .bit9_in(bit9_in), .consume(consume),
        .full(hold_full), .chr(chr)
    );

    uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .run(tx_en), .bit_tick(bit_tick),
        .nine_bit(nine_bit), .hold_full(hold_full), .chr(chr),
        .consume(consume), .line(line), .empty(tsr_empty)
    );

    // Output gating: pin released high when the port is disconnected.
    assign txd        = port_en ? line : 1'b1;
    assign hold_empty = !hold_full;
    assign tx_irq     = int_en && tx_en && hold_empty;

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (txd && tsr_empty && hold_empty));
    assert_irq_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && wr_en) |=> !hold_empty);

endmodule

// File: tb/sim_uart_tx_buf.sv
module sim_uart_tx_buf;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 0, port_en = 1, sync_mode = 0, hi_speed = 0, nine_bit = 0, bit9_in = 0;
    logic [7:0] divisor = 0;
    logic wr_en = 0;
    logic [7:0] wr_data = 0;
    logic int_en = 0;
    logic txd, tsr_empty, hold_empty, tx_irq;

    int total = 0, bad = 0;
    int cyc = 0;
    logic [7:0] q_data [4];
    logic       q_b9   [4];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_tx_buf u0 (.*);

    function automatic int exp_period(input logic [7:0] d, input logic s, input logic h);
        int m;
        m = s ? 4 : (h ? 16 : 64);
        return (int'(d) + 1) * m;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    task automatic write_char(input logic [7:0] d, input logic b9);
        @(negedge clk);
        while (!hold_empty) @(negedge clk);
        wr_data = d; bit9_in = b9; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic configure(input logic [7:0] d, input logic s, input logic h, input logic nb);
        @(negedge clk);
        tx_en = 0;
        @(negedge clk);
        divisor = d; sync_mode = s; hi_speed = h; nine_bit = nb;
        tx_en = 1;
    endtask

    // Receives n frames from q_data/q_b9, checking content and spacing (R3, R4, R5, R9).
    task automatic recv(input int n);
        int p, flen, prev;
        p = exp_period(divisor, sync_mode, hi_speed);
        flen = nine_bit ? 11 : 10;
        prev = 0;
        for (int k = 0; k < n; k++) begin
            logic [8:0] got;
            @(negedge clk);
            while (txd !== 1'b0) @(negedge clk);
            if (k > 0) chk("R5 frame spacing", cyc - prev, flen * p);
            prev = cyc;
            repeat (p / 2) @(negedge clk);
            chk("R3 start bit", int'(txd), 0);
            chk("R9 busy mid-frame", int'(tsr_empty), 0);
            got = '0;
            for (int b = 0; b < flen - 2; b++) begin
                repeat (p) @(negedge clk);
                got[b] = txd;
            end
            chk("R3 data LSB first", int'(got[7:0]), int'(q_data[k]));
            if (nine_bit) chk("R4 ninth bit", int'(got[8]), int'(q_b9[k]));
            repeat (p) @(negedge clk);
            chk("R3 stop bit", int'(txd), 1);
        end
        repeat (p) @(negedge clk);
        chk("R9 empty after burst", int'(tsr_empty), 1);
        chk("R3 idle high", int'(txd), 1);
    endtask

    task automatic burst(input int n);
        fork
            for (int k = 0; k < n; k++) write_char(q_data[k], q_b9[k]);
            recv(n);
        join
    endtask

    // Measures the start bit length with bit 0 of the data high (R1, R2).
    task automatic period_check(input logic [7:0] d, input logic s, input logic h);
        int n;
        configure(d, s, h, 0);
        write_char(8'h55, 0);
        while (txd !== 1'b0) @(negedge clk);
        n = 0;
        while (txd === 1'b0) begin @(negedge clk); n++; end
        chk("R1 R2 bit period", n, exp_period(d, s, h));
        while (!tsr_empty) @(negedge clk);
    endtask

    initial begin
        int lows;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        int_en = 1;
        chk("reset txd R3", int'(txd), 1);
        chk("reset tsr_empty R9", int'(tsr_empty), 1);
        chk("reset hold_empty", int'(hold_empty), 1);
        chk("reset irq R7", int'(tx_irq), 0);
        rst_n = 1;
        @(negedge clk);

        // R7: interrupt qualification
        tx_en = 1; @(negedge clk);
        chk("R7 irq when free", int'(tx_irq), 1);
        int_en = 0; @(negedge clk);
        chk("R7 irq masked", int'(tx_irq), 0);
        int_en = 1;

        // R1/R2: each multiplier and several divisors
        period_check(8'd0, 0, 0);
        period_check(8'd1, 0, 1);
        period_check(8'd3, 1, 0);
        period_check(8'd2, 1, 1);
        period_check(8'd0, 0, 1);

        // R3/R5: directed back-to-back 8-bit burst
        configure(8'd0, 1, 0, 0);
        q_data[0] = 8'h00; q_data[1] = 8'hFF; q_data[2] = 8'hA5;
        q_b9[0] = 0; q_b9[1] = 0; q_b9[2] = 0;
        burst(3);

        // R4: 9-bit with both ninth-bit values
        configure(8'd1, 0, 1, 1);
        q_data[0] = 8'h3C; q_b9[0] = 1; q_data[1] = 8'hC3; q_b9[1] = 0;
        burst(2);

        // R6: second write while full is ignored
        configure(8'd1, 1, 0, 0);
        @(negedge clk);
        wr_data = 8'h81; wr_en = 1; @(negedge clk);
        wr_data = 8'h7E; @(negedge clk);
        wr_en = 0;
        chk("R6 hold stays full", int'(hold_empty), 0);
        chk("R6 irq low while full", int'(tx_irq), 0);
        q_data[0] = 8'h81;
        recv(1);
        lows = 0;
        repeat (30 * 8) begin @(negedge clk); if (txd === 1'b0) lows++; end
        chk("R6 no second frame", lows, 0);

        // R8: port disconnected keeps the line high
        configure(8'd0, 1, 0, 0);
        port_en = 0;
        lows = 0;
        write_char(8'h00, 0);
        repeat (60) begin @(negedge clk); if (txd === 1'b0) lows++; end
        chk("R8 line held high", lows, 0);
        port_en = 1;
        while (!tsr_empty) @(negedge clk);

        // R10: flush mid-frame and writes ignored while disabled
        configure(8'd0, 1, 0, 0);
        write_char(8'h00, 0);
        write_char(8'h00, 0);
        while (txd !== 1'b0) @(negedge clk);
        tx_en = 0;
        @(negedge clk);
        chk("R10 flush txd", int'(txd), 1);
        chk("R10 flush tsr_empty", int'(tsr_empty), 1);
        chk("R10 flush hold_empty", int'(hold_empty), 1);
        wr_data = 8'h00; wr_en = 1; @(negedge clk); wr_en = 0;
        chk("R10 write ignored", int'(hold_empty), 1);
        chk("R10 R7 irq off when disabled", int'(tx_irq), 0);
        tx_en = 1;
        lows = 0;
        repeat (100) begin @(negedge clk); if (txd === 1'b0) lows++; end
        chk("R10 nothing sent", lows, 0);

        // Random bursts across modes (R1-style spacing, R3, R4, R5)
        for (int t = 0; t < 10; t++) begin
            int n;
            configure(8'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            if (!sync_mode && !hi_speed) divisor = 0;
            n = $urandom_range(1, 4);
            for (int k = 0; k < n; k++) begin
                q_data[k] = 8'($urandom);
                q_b9[k] = 1'($urandom_range(0, 1));
            end
            burst(n);
        end

        finish_run();
    end
endmodule